// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner with Run-Time Endianness

This block sits between a 32-bit core and a word-wide data memory that is addressed in bytes. For a store, it takes the byte address, the access size and the store data. It produces one write enable per byte lane and places the data on the lanes that the address selects.

For a load, it takes the raw memory word and picks out the addressed byte, halfword or word. It then sign-extends or zero-extends that value to 32 bits.

A mode input chooses big-endian or little-endian byte numbering on every access. An access whose address is not a multiple of its size is never split into two accesses. Instead the block raises a trap, suppresses every write enable and returns zero load data, all in the same cycle.

The block is purely combinational. It keeps the house naming and layout, but it has no state register because nothing in the function needs one. Its sub-blocks are:

- `lsa_align_check`: the alignment decision.
- `lsa_store_path`: lane enables and data placement for stores.
- `lsa_load_path`: lane selection and extension for loads.

Top module: `lsa_aligner`

## Requirements
- R1: Size codes on `acc_size` are 0 = byte, 1 = halfword, 2 = word, 3 = reserved. `trap` is 1 exactly when a load or store is requested and one of the following holds:
  - the size is halfword and `addr[0]` is 1;
  - the size is word and `addr[1:0]` is not 0;
  - the size is reserved.
  Byte accesses never trap.
- R2: While `trap` is 1, `mem_be` is all zero, `mem_wdata` is zero and `load_data` is zero.
- R3: Lane i (`mem_be[i]` and bits 8i+7..8i of the data buses) holds the byte at address offset i in little-endian mode (`big_endian` = 0), and offset 3-i in big-endian mode. An aligned store enables exactly the lanes of the bytes it writes: 1 for a byte, 2 for a halfword, 4 for a word.
- R4: An aligned store of n bytes writes the low n bytes of `st_data`. In little-endian mode the least significant of those bytes goes to the lowest address. In big-endian mode the most significant goes to the lowest address. Lanes that are not enabled carry zero on `mem_wdata`.
- R5: An aligned unsigned byte or halfword load (`ld_unsigned` = 1) returns the addressed bytes, assembled in the order set by R3's lane mapping, in the low bits of `load_data`, with the upper bits zero.
- R6: An aligned signed byte or halfword load (`ld_unsigned` = 0) fills every upper bit of `load_data` with the most significant bit of the loaded value.
- R7: An aligned word load returns all four bytes in the mode's order, whatever the value of `ld_unsigned`.
- R8: With neither `ld_req` nor `st_req` asserted, `trap`, `mem_be`, `mem_wdata` and `load_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_req | input | 1 | Load access requested this cycle |
| st_req | input | 1 | Store access requested this cycle |
| acc_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| ld_unsigned | input | 1 | 1 = zero-extend loads, 0 = sign-extend |
| big_endian | input | 1 | 1 = lowest address holds the most significant byte |
| addr | input | 32 | Byte address of the access |
| st_data | input | 32 | Store value, right-justified |
| mem_rdata | input | 32 | Raw word read from memory |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Store data placed on its lanes |
| load_data | output | 32 | Selected and extended load result |
| trap | output | 1 | Misaligned or illegal-size access |

## Verification
The embedded assertions check, on every evaluation, these properties:
- a trap never coexists with a write enable or with non-zero load data;
- an enabled store lights exactly the lane count its size demands;
- disabled lanes carry zero data;
- signed and unsigned narrow loads have the correct upper-bit fill.

Only the bench's scenarios can show that the right lanes and the right byte order are chosen in each endian mode, at every offset and size. They also show that misalignment is judged correctly per size, and that the reserved size code always traps.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    // Number of bytes touched by an access size (reserved maps to zero).
    function automatic int unsigned size_bytes(acc_size_e s);
        unique case (s)
            ACC_BYTE: return 1;
            ACC_HALF: return 2;
            ACC_WORD: return 4;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
    import lsa_pkg::*;
(
    input  logic       active,
    input  acc_size_e  size,
    input  logic [1:0] addr_lo,
    output logic       fault
);
    logic misaligned;

    always_comb begin
        unique case (size)
            ACC_BYTE: misaligned = 1'b0;
            ACC_HALF: misaligned = addr_lo[0];
            ACC_WORD: misaligned = |addr_lo;
            default:  misaligned = 1'b1;
        endcase
        fault = active && misaligned;
    end

    always_comb begin
        if (active && size == ACC_BYTE) begin
            AST_BYTE_NEVER_FAULTS: assert (!fault)
                else $error("byte access faulted"); // R1
        end
    end
endmodule

// File: rtl/lsa_store_path.sv
module lsa_store_path #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              active,
    input  logic [LANES-1:0]  size_mask,
    input  logic [LANE_W-1:0] lane_lo,
    input  logic [DATA_W-1:0] st_data,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] byte_keep;

    for (genvar g = 0; g < LANES; g++) begin : g_keep
        assign byte_keep[8*g +: 8] = {8{size_mask[g]}};
    end

    always_comb begin
        if (active) begin
            be    = size_mask << lane_lo;
            wdata = (st_data & byte_keep) << {lane_lo, 3'b000};
        end else begin
            be    = '0;
            wdata = '0;
        end
    end

    always_comb begin
        if (active) begin
            AST_BE_COUNT: assert ($countones(be) == $countones(size_mask))
                else $error("lane count mismatch"); // R3
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_idle_lane
        always_comb begin
            if (!be[g]) begin
                AST_IDLE_LANE_ZERO: assert (wdata[8*g +: 8] == 8'h00)
                    else $error("disabled lane carries data"); // R4
            end
        end
    end
endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              active,
    input  acc_size_e         size,
    input  logic              zero_ext,
    input  logic [LANE_W-1:0] lane_lo,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = rdata >> {lane_lo, 3'b000};
        if (!active) begin
            data = '0;
        end else begin
            unique case (size)
                ACC_BYTE: data = {{(DATA_W-8){!zero_ext && shifted[7]}}, shifted[7:0]};
                ACC_HALF: data = {{(DATA_W-16){!zero_ext && shifted[15]}}, shifted[15:0]};
                default:  data = shifted;
            endcase
        end
    end

    always_comb begin
        if (active && size == ACC_BYTE && !zero_ext) begin
            AST_SIGN_FILL_BYTE: assert (data[DATA_W-1:8] == {(DATA_W-8){data[7]}})
                else $error("byte sign fill wrong"); // R6
        end
        if (active && size == ACC_HALF && !zero_ext) begin
            AST_SIGN_FILL_HALF: assert (data[DATA_W-1:16] == {(DATA_W-16){data[15]}})
                else $error("half sign fill wrong"); // R6
        end
        if (active && size == ACC_BYTE && zero_ext) begin
            AST_ZERO_FILL_BYTE: assert (data[DATA_W-1:8] == '0)
                else $error("byte zero fill wrong"); // R5
        end
    end
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              ld_req,
    input  logic              st_req,
    input  logic [1:0]        acc_size,
    input  logic              ld_unsigned,
    input  logic              big_endian,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] load_data,
    output logic              trap
);
    acc_size_e         size;
    logic [LANE_W-1:0] lane_lo;
    logic [LANES-1:0]  size_mask;
    int unsigned       nbytes;

    assign size = acc_size_e'(acc_size);

    // Lowest lane covered: offset itself when little-endian, mirrored otherwise.
    always_comb begin
        nbytes    = size_bytes(size);
        size_mask = LANES'((1 << nbytes) - 1);
        if (big_endian)
            lane_lo = LANE_W'(LANES - int'(addr[LANE_W-1:0]) - int'(nbytes));
        else
            lane_lo = addr[LANE_W-1:0];
    end

    lsa_align_check u_align (
        .active  (ld_req || st_req),
        .size    (size),
        .addr_lo (addr[1:0]),
        .fault   (trap)
    );

    lsa_store_path #(.DATA_W(DATA_W)) u_store (
        .active    (st_req && !trap),
        .size_mask (size_mask),
        .lane_lo   (lane_lo),
        .st_data   (st_data),
        .be        (mem_be),
        .wdata     (mem_wdata)
    );

    lsa_load_path #(.DATA_W(DATA_W)) u_load (
        .active   (ld_req && !trap),
        .size     (size),
        .zero_ext (ld_unsigned),
        .lane_lo  (lane_lo),
        .rdata    (mem_rdata),
        .data     (load_data)
    );

    always_comb begin
        if (trap) begin
            AST_TRAP_NO_WRITE: assert (mem_be == '0 && mem_wdata == '0)
                else $error("write during trap"); // R2
            AST_TRAP_LOAD_ZERO: assert (load_data == '0)
                else $error("load data during trap"); // R2
        end
        if (!ld_req && !st_req) begin
            AST_IDLE_QUIET: assert (!trap && mem_be == '0 && load_data == '0)
                else $error("activity while idle"); // R8
        end
    end
endmodule

// File: tb/tb_lsa_aligner.sv
module tb_lsa_aligner;
    logic        clk = 1'b0;
    logic        ld_req, st_req, ld_unsigned, big_endian;
    logic [1:0]  acc_size;
    logic [31:0] addr, st_data, mem_rdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, load_data;
    logic        trap;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    lsa_aligner dut (
        .ld_req(ld_req), .st_req(st_req), .acc_size(acc_size),
        .ld_unsigned(ld_unsigned), .big_endian(big_endian), .addr(addr),
        .st_data(st_data), .mem_rdata(mem_rdata), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .load_data(load_data), .trap(trap)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic st, input logic [1:0] sz,
                         input logic uns, input logic be_mode, input logic [31:0] a,
                         input logic [31:0] wd, input logic [31:0] rd);
        @(posedge clk);
        ld_req = ld; st_req = st; acc_size = sz; ld_unsigned = uns;
        big_endian = be_mode; addr = a; st_data = wd; mem_rdata = rd;
        @(negedge clk);
    endtask

    function automatic bit misal(input int sz, input int off);
        return (sz == 3) || (sz == 1 && off[0]) || (sz == 2 && off != 0);
    endfunction

    task automatic t_idle();
        drive(0, 0, 2'd1, 0, 0, 32'h0000_0003, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R8 trap idle", {31'd0, trap}, 32'd0);
        chk("R8 be idle", {28'd0, mem_be}, 32'd0);
        chk("R8 wdata idle", mem_wdata, 32'd0);
        chk("R8 load idle", load_data, 32'd0);
    endtask

    task automatic t_stores();
        for (int e = 0; e < 2; e++)
            for (int sz = 0; sz < 4; sz++)
                for (int off = 0; off < 4; off++) begin
                    logic [31:0] wd, exp_wd;
                    logic [3:0]  exp_be;
                    int n;
                    wd = 32'hA1B2_C3D4 ^ {8'(sz), 8'(off), 8'(e), 8'h5A};
                    drive(0, 1, 2'(sz), 0, e[0], 32'h2000_0040 | 32'(off), wd, 32'hDEAD_BEEF);
                    if (misal(sz, off)) begin
                        chk("R1 store trap", {31'd0, trap}, 32'd1);
                        chk("R2 store be on trap", {28'd0, mem_be}, 32'd0);
                        chk("R2 store wdata on trap", mem_wdata, 32'd0);
                    end else begin
                        n = 1 << sz;
                        exp_be = '0; exp_wd = '0;
                        for (int k = 0; k < n; k++) begin
                            int a, lane;
                            a = off + k;
                            lane = e ? 3 - a : a;
                            exp_be[lane] = 1'b1;
                            exp_wd[8*lane +: 8] = e ? wd[8*(n-1-k) +: 8] : wd[8*k +: 8];
                        end
                        chk("R1 store no trap", {31'd0, trap}, 32'd0);
                        chk("R3 store lanes", {28'd0, mem_be}, {28'd0, exp_be});
                        chk("R4 store data", mem_wdata, exp_wd);
                    end
                end
    endtask

    task automatic t_loads(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3);
        logic [7:0] b [4];
        b[0] = b0; b[1] = b1; b[2] = b2; b[3] = b3;
        for (int e = 0; e < 2; e++)
            for (int uns = 0; uns < 2; uns++)
                for (int sz = 0; sz < 4; sz++)
                    for (int off = 0; off < 4; off++) begin
                        logic [31:0] rd, val;
                        int n;
                        for (int i = 0; i < 4; i++)
                            rd[8*(e ? 3 - i : i) +: 8] = b[i];
                        drive(1, 0, 2'(sz), uns[0], e[0], 32'h0000_1100 | 32'(off), 32'h0, rd);
                        if (misal(sz, off)) begin
                            chk("R1 load trap", {31'd0, trap}, 32'd1);
                            chk("R2 load zero on trap", load_data, 32'd0);
                        end else begin
                            n = 1 << sz;
                            val = '0;
                            for (int k = 0; k < n; k++) begin
                                if (e) val = (val << 8) | 32'(b[off+k]);
                                else   val = val | (32'(b[off+k]) << (8*k));
                            end
                            if (n < 4 && uns == 0 && val[8*n-1])
                                val = val | (32'hFFFF_FFFF << (8*n));
                            chk("R1 load no trap", {31'd0, trap}, 32'd0);
                            if (n == 4)      chk("R7 word load", load_data, val);
                            else if (uns)    chk("R5 unsigned load", load_data, val);
                            else             chk("R6 signed load", load_data, val);
                        end
                    end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        ld_req = 0; st_req = 0; acc_size = 0; ld_unsigned = 0; big_endian = 0;
        addr = 0; st_data = 0; mem_rdata = 0;
        t_idle();
        t_stores();
        t_loads(8'h7E, 8'h81, 8'hF0, 8'h05);
        t_loads(8'h12, 8'hC4, 8'h6A, 8'h9D);
        t_idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule